// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block is a clocked front-end that lets on-chip logic read and write an external asynchronous static RAM. The RAM holds 512K words of 16 bits. A client presents one word request at a time. Each request carries a 19-bit word address, 16 bits of write data, a 2-bit lane mask and a write flag. The request is taken when valid and ready are both high. The controller turns each request into a strobe sequence on the memory pins. It finishes the request with a one-cycle done pulse, and for a read it returns the data in the same cycle as that pulse.

The RAM has no clock, so every strobe is held for a whole number of system-clock cycles. That number comes from the RAM access time and the clock period, rounded up. The RAM is selected through two chip selects of opposite polarity. Each byte has its own active-low lane enable. Whenever no access is in progress, the controller parks the RAM in standby and leaves the shared data bus undriven.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, and in every cycle where `req_ready` is high, the memory is in standby: `mem_cs1_n`=1, `mem_cs2`=0, `mem_lb_n`=1, `mem_ub_n`=1, `mem_oe_n`=1, `mem_we_n`=1, and `rsp_done`=0.
- R2: In a write, the chip selects, the address and the lane enables are already active in the cycle before `mem_we_n` falls. `mem_we_n` stays low for exactly WAIT_CYC cycles. The write data stays driven for one further cycle with `mem_we_n` high.
- R3: WAIT_CYC equals the ceiling of ACCESS_PS / CLK_PS, with a minimum of 1. With the defaults (55000 ps, 8000 ps) it is 7.
- R4: In a read, `mem_oe_n` falls in the same cycle as the chip selects become active. `mem_we_n` stays high throughout. `mem_oe_n` stays low for exactly WAIT_CYC cycles. The data bus is sampled at the end of the last of those cycles.
- R5: Mask bit 0 selects the low lane (data bits 7:0, `mem_lb_n`). Mask bit 1 selects the high lane (bits 15:8, `mem_ub_n`). A write changes only the enabled lanes. A read returns zero in every lane that is not enabled.
- R6: A request with mask 2'b00 is done in the cycle after it is accepted. No chip select, output enable or write enable is asserted for it.
- R7: `rsp_done` is high for exactly one cycle per request, and responses come back in request order. For a read, `rsp_rdata` is valid in that cycle.
- R8: The output enable and the controller's data driver are never active together. After a read, at least one cycle with the output enable inactive passes before a write drives the bus.
- R9: `req_ready` is high only while the controller is idle. It falls at acceptance and rises in the cycle after `rsp_done`. Latency from acceptance to done is WAIT_CYC+2 cycles for a write, WAIT_CYC+1 for a read and 1 for an empty mask.
- R10: `mem_addr` holds steady while either strobe (`mem_we_n` or `mem_oe_n`) is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask (bit 0 low byte, bit 1 high byte) |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with `rsp_done` for reads |
| mem_addr | output | 19 | Memory address bus |
| mem_cs1_n | output | 1 | Chip select, active low |
| mem_cs2 | output | 1 | Chip select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Low byte lane enable, active low |
| mem_ub_n | output | 1 | High byte lane enable, active low |
| mem_dq | inout | 16 | Bidirectional three-state data bus |

## Verification
The stimulus mixes full-word, low-only and high-only writes over addresses that share or differ in their upper bits. A wrong lane enable, or an address bit that is dropped, then shows up as corrupt read-back data. Reads with partial masks show whether disabled lanes are zeroed rather than passed through. Empty-mask requests, in both directions, show whether the skip path really leaves the memory untouched. Back-to-back read-then-write and write-then-read pairs test the turnaround gap and confirm that the strobe widths match the computed wait count.

// File: rtl/sram_lane_pkg.sv
`timescale 1ns/1ps
package sram_lane_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WSETUP,
      ST_WPULSE,
      ST_WHOLD,
      ST_RACC,
      ST_RTURN,
      ST_SKIP
   } lane_st_e;

   // strobe length in clock cycles: ceiling of access over period, never below one
   function automatic int unsigned wait_cycles(input int unsigned access_ps,
                                               input int unsigned clk_ps);
      int unsigned c;
      c = (access_ps + clk_ps - 1) / clk_ps;
      return (c < 1) ? 1 : c;
   endfunction

endpackage

// File: rtl/sram_wait_timer.sv
`timescale 1ns/1ps
module sram_wait_timer #(
   parameter int unsigned LIMIT = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expire
);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("sram_wait_timer: LIMIT must be at least 1");
      end

      if (LIMIT == 1) begin : g_single
         // one-cycle strobe: every cycle is the last one
         logic unused_in;
         assign unused_in = clk ^ rst_n ^ load;
         assign expire    = 1'b1;
      end else begin : g_count
         localparam int unsigned CW = $clog2(LIMIT);
         localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (load)
               cnt_q <= '0;
            else if (cnt_q != LAST)
               cnt_q <= cnt_q + 1'b1;
         end

         assign expire = (cnt_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/sram_lane_bus.sv
`timescale 1ns/1ps
module sram_lane_bus #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned LANES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              drv_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic [LANES-1:0]  lane_en,
   input  logic              capture,
   output logic [DATA_W-1:0] rdata,
   inout  wire  [DATA_W-1:0] dq
);

   localparam int unsigned LANE_W = DATA_W / LANES;

   generate
      if (DATA_W % LANES != 0) begin : g_bad_split
         $error("sram_lane_bus: DATA_W must divide evenly into LANES");
      end

      for (genvar l = 0; l < LANES; l++) begin : g_lane
         assign dq[l*LANE_W +: LANE_W] = drv_en ? wdata[l*LANE_W +: LANE_W]
                                                : {LANE_W{1'bz}};

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               rdata[l*LANE_W +: LANE_W] <= '0;
            else if (capture)
               rdata[l*LANE_W +: LANE_W] <= lane_en[l] ? dq[l*LANE_W +: LANE_W]
                                                       : {LANE_W{1'b0}};
         end
      end
   endgenerate

   // R8
   drive_vs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      capture |-> !drv_en);

endmodule

// File: rtl/sram_lane_seq.sv
`timescale 1ns/1ps
module sram_lane_seq
   import sram_lane_pkg::*;
#(
   parameter int unsigned ADDR_W = 19,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned LANES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_mask,
   output logic              rsp_done,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              cs1_n,
   output logic              cs2,
   output logic              oe_n,
   output logic              we_n,
   output logic [LANES-1:0]  be_n,
   output logic              drv_en,
   output logic              capture,
   output logic [DATA_W-1:0] wdata_q,
   output logic [LANES-1:0]  lane_en,
   output logic              tmr_load,
   input  logic              tmr_expire
);

   lane_st_e          st_q, st_d;
   logic [ADDR_W-1:0] addr_q;
   logic [LANES-1:0]  mask_q;
   logic              accept;
   logic              selected;

   assign accept = req_valid && (st_q == ST_IDLE);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:
            if (req_valid) begin
               if (req_mask == '0)  st_d = ST_SKIP;
               else if (req_write)  st_d = ST_WSETUP;
               else                 st_d = ST_RACC;
            end
         ST_WSETUP: st_d = ST_WPULSE;
         ST_WPULSE: if (tmr_expire) st_d = ST_WHOLD;
         ST_WHOLD:  st_d = ST_IDLE;
         ST_RACC:   if (tmr_expire) st_d = ST_RTURN;
         ST_RTURN:  st_d = ST_IDLE;
         ST_SKIP:   st_d = ST_IDLE;
         default:   st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         addr_q  <= '0;
         mask_q  <= '0;
         wdata_q <= '0;
      end else begin
         st_q <= st_d;
         if (accept) begin
            addr_q  <= req_addr;
            mask_q  <= req_mask;
            wdata_q <= req_wdata;
         end
      end
   end

   assign selected  = (st_q == ST_WSETUP) || (st_q == ST_WPULSE) ||
                      (st_q == ST_WHOLD)  || (st_q == ST_RACC);
   assign req_ready = (st_q == ST_IDLE);
   assign rsp_done  = (st_q == ST_WHOLD) || (st_q == ST_RTURN) || (st_q == ST_SKIP);
   assign mem_addr  = addr_q;
   assign cs1_n     = !selected;
   assign cs2       = selected;
   assign be_n      = selected ? ~mask_q : '1;
   assign lane_en   = mask_q;
   assign we_n      = (st_q != ST_WPULSE);
   assign oe_n      = (st_q != ST_RACC);
   assign drv_en    = (st_q == ST_WSETUP) || (st_q == ST_WPULSE) || (st_q == ST_WHOLD);
   assign capture   = (st_q == ST_RACC) && tmr_expire;
   assign tmr_load  = (st_q == ST_WSETUP) ||
                      (accept && !req_write && (req_mask != '0));

   // R1
   idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (cs1_n && !cs2 && (&be_n) && oe_n && we_n && !rsp_done));

   // R2
   we_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(we_n) |-> $past(!cs1_n && cs2 && drv_en));

   // R4
   oe_with_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(oe_n) |-> ($fell(cs1_n) && we_n));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   // R9
   ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> req_ready);

   // R10
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((!we_n || !oe_n) && $past(!cs1_n)) |-> $stable(mem_addr));

endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
module sram_lane_ctrl
   import sram_lane_pkg::*;
#(
   parameter int unsigned ADDR_W    = 19,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned CLK_PS    = 8000,
   parameter int unsigned ACCESS_PS = 55000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [1:0]        req_mask,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs1_n,
   output logic              mem_cs2,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic              mem_lb_n,
   output logic              mem_ub_n,
   inout  wire  [DATA_W-1:0] mem_dq
);

   localparam int unsigned LANES    = 2;
   localparam int unsigned WAIT_CYC = wait_cycles(ACCESS_PS, CLK_PS);

   generate
      if (CLK_PS == 0) begin : g_bad_clk
         $error("sram_lane_ctrl: CLK_PS must be non-zero");
      end
      if (DATA_W % LANES != 0) begin : g_bad_width
         $error("sram_lane_ctrl: DATA_W must be even");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("sram_lane_ctrl: ADDR_W must be positive");
      end
   endgenerate

   logic              drv_en;
   logic              capture;
   logic [DATA_W-1:0] wdata_q;
   logic [LANES-1:0]  lane_en;
   logic [LANES-1:0]  be_n;
   logic              tmr_load;
   logic              tmr_expire;

   sram_lane_seq #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .LANES  (LANES)
   ) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_write  (req_write),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .req_mask   (req_mask),
      .rsp_done   (rsp_done),
      .mem_addr   (mem_addr),
      .cs1_n      (mem_cs1_n),
      .cs2        (mem_cs2),
      .oe_n       (mem_oe_n),
      .we_n       (mem_we_n),
      .be_n       (be_n),
      .drv_en     (drv_en),
      .capture    (capture),
      .wdata_q    (wdata_q),
      .lane_en    (lane_en),
      .tmr_load   (tmr_load),
      .tmr_expire (tmr_expire)
   );

   sram_wait_timer #(
      .LIMIT (WAIT_CYC)
   ) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (tmr_load),
      .expire (tmr_expire)
   );

   sram_lane_bus #(
      .DATA_W (DATA_W),
      .LANES  (LANES)
   ) i_bus (
      .clk     (clk),
      .rst_n   (rst_n),
      .drv_en  (drv_en),
      .wdata   (wdata_q),
      .lane_en (lane_en),
      .capture (capture),
      .rdata   (rsp_rdata),
      .dq      (mem_dq)
   );

   assign mem_lb_n = be_n[0];
   assign mem_ub_n = be_n[1];

   // R8
   oe_drive_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && drv_en));

   // R8
   turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv_en) |-> $past(mem_oe_n));

   // R5
   lane_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs1_n) |-> (!mem_lb_n || !mem_ub_n));

endmodule

// File: tb/test_sram_lane_ctrl.sv
`timescale 1ns/1ps
module test_sram_lane_ctrl;

   localparam int TB_WAIT = 7;   // ceil(55000 / 8000)

   typedef struct packed {
      logic        wr;
      logic [18:0] addr;
      logic [15:0] exp;
      logic [1:0]  mask;
      logic [31:0] issue;
      logic [31:0] lat;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [18:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_mask = '0;
   logic        rsp_done;
   logic [15:0] rsp_rdata;
   logic [18:0] mem_addr;
   logic        mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
   wire  [15:0] mem_dq;

   int n_cmp = 0;
   int n_bad = 0;
   int ncyc  = 0;

   item_t       sb_q[$];
   logic [15:0] ref_mem [256];
   logic [15:0] mdl_dat [256];
   logic [18:0] mdl_tag [256];

   always #4 clk = ~clk;
   always @(posedge clk) ncyc <= ncyc + 1;

   sram_lane_ctrl #(
      .ADDR_W    (19),
      .DATA_W    (16),
      .CLK_PS    (8000),
      .ACCESS_PS (55000)
   ) i_sram_lane_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .req_mask  (req_mask),
      .rsp_done  (rsp_done),
      .rsp_rdata (rsp_rdata),
      .mem_addr  (mem_addr),
      .mem_cs1_n (mem_cs1_n),
      .mem_cs2   (mem_cs2),
      .mem_oe_n  (mem_oe_n),
      .mem_we_n  (mem_we_n),
      .mem_lb_n  (mem_lb_n),
      .mem_ub_n  (mem_ub_n),
      .mem_dq    (mem_dq)
   );

   // ---------------- memory model ----------------
   logic        sel;
   logic [15:0] mdl_word;
   assign sel      = !mem_cs1_n && mem_cs2;
   assign mdl_word = (mdl_tag[mem_addr[7:0]] == mem_addr) ? mdl_dat[mem_addr[7:0]] : 16'hDEAD;
   assign mem_dq[7:0]  = (sel && !mem_oe_n && mem_we_n && !mem_lb_n) ? mdl_word[7:0]  : 8'bz;
   assign mem_dq[15:8] = (sel && !mem_oe_n && mem_we_n && !mem_ub_n) ? mdl_word[15:8] : 8'bz;

   initial begin
      for (int i = 0; i < 256; i++) begin
         mdl_dat[i] = '0;
         mdl_tag[i] = 19'(i);
         ref_mem[i] = '0;
      end
   end

   always @(posedge clk) begin
      if (sel && !mem_we_n) begin
         logic [7:0]  ix;
         logic [15:0] w;
         ix = mem_addr[7:0];
         w  = (mdl_tag[ix] == mem_addr) ? mdl_dat[ix] : 16'h0000;
         if (!mem_lb_n) w[7:0]  = mem_dq[7:0];
         if (!mem_ub_n) w[15:8] = mem_dq[15:8];
         mdl_dat[ix] = w;
         mdl_tag[ix] = mem_addr;
      end
   end

   // ---------------- check helper ----------------
   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // ---------------- driver ----------------
   task automatic issue(input logic wr, input logic [18:0] a,
                        input logic [15:0] d, input logic [1:0] m);
      item_t       it;
      logic [15:0] cur;
      do @(negedge clk); while (!req_ready);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_wdata = d;
      req_mask  = m;
      cur = ref_mem[a[7:0]];
      it.wr    = wr;
      it.addr  = a;
      it.mask  = m;
      it.issue = 32'(ncyc);
      it.lat   = (m == 2'b00) ? 32'd1 : (wr ? 32'(TB_WAIT + 2) : 32'(TB_WAIT + 1));
      if (wr) begin
         if (m[0]) cur[7:0]  = d[7:0];
         if (m[1]) cur[15:8] = d[15:8];
         ref_mem[a[7:0]] = cur;
         it.exp = '0;
      end else begin
         it.exp = {m[1] ? cur[15:8] : 8'h00, m[0] ? cur[7:0] : 8'h00};
      end
      sb_q.push_back(it);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // ---------------- monitor ----------------
   logic        p_done = 1'b0, p_we_n = 1'b1, p_oe_n = 1'b1, p_sel = 1'b0;
   logic        p_lb = 1'b1, p_ub = 1'b1;
   logic [18:0] p_addr = '0;
   int          we_run = 0, oe_run = 0, last_oe = -100;

   always @(negedge clk) begin
      if (rst_n) begin
         if (rsp_done) begin
            if (sb_q.size() == 0) begin
               chk(1'b0, "R7", "done with no pending request", 32'd1, 32'd0);
            end else begin
               item_t it;
               it = sb_q.pop_front();
               chk(32'(ncyc) - it.issue == it.lat, "R9", "accept-to-done latency",
                   32'(ncyc) - it.issue, it.lat);
               if (!it.wr && it.mask != 2'b00)
                  chk(rsp_rdata == it.exp, "R5", "read data", 32'(rsp_rdata), 32'(it.exp));
               if (it.mask == 2'b00)
                  chk(mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n,
                      "R6", "strobes during empty-mask request",
                      {26'd0, mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n},
                      32'b101111);
            end
            chk(!p_done, "R7", "done width", 32'(p_done), 32'd0);
         end
         if (req_ready)
            chk(mem_cs1_n && !mem_cs2 && mem_lb_n && mem_ub_n && mem_oe_n && mem_we_n && !rsp_done,
                "R1", "standby while idle",
                {25'd0, mem_cs1_n, mem_cs2, mem_lb_n, mem_ub_n, mem_oe_n, mem_we_n, rsp_done},
                32'b1011110);
         // write pulse width and setup
         if (!mem_we_n) begin
            if (p_we_n)
               chk(p_sel && p_lb == mem_lb_n && p_ub == mem_ub_n && p_addr == mem_addr,
                   "R2", "setup cycle before write strobe", 32'(p_sel), 32'd1);
            we_run++;
         end else if (we_run > 0) begin
            chk(we_run == TB_WAIT, "R3", "write strobe length", 32'(we_run), 32'(TB_WAIT));
            chk(sel, "R2", "hold cycle after write strobe", 32'(sel), 32'd1);
            we_run = 0;
         end
         // read strobe width
         if (!mem_oe_n) begin
            if (p_oe_n) chk(!p_sel && sel, "R4", "oe together with select", 32'(p_sel), 32'd0);
            chk(mem_we_n, "R4", "we high during read", 32'(mem_we_n), 32'd1);
            oe_run++;
            last_oe = ncyc;
         end else if (oe_run > 0) begin
            chk(oe_run == TB_WAIT, "R4", "read strobe length", 32'(oe_run), 32'(TB_WAIT));
            oe_run = 0;
         end
         // turnaround: a write phase never directly follows a read strobe
         if (sel && mem_oe_n)
            chk(ncyc - last_oe >= 2, "R8", "read-to-write gap", 32'(ncyc - last_oe), 32'd2);
         if ((!mem_we_n || !mem_oe_n) && p_sel)
            chk(mem_addr == p_addr, "R10", "address stable", 32'(mem_addr), 32'(p_addr));
      end
      p_done = rsp_done;
      p_we_n = mem_we_n;
      p_oe_n = mem_oe_n;
      p_sel  = sel;
      p_lb   = mem_lb_n;
      p_ub   = mem_ub_n;
      p_addr = mem_addr;
   end

   // ---------------- watchdog ----------------
   initial begin
      repeat (50000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(req_ready && mem_cs1_n && !mem_cs2 && mem_lb_n && mem_ub_n && mem_oe_n && mem_we_n && !rsp_done,
          "R1", "reset state", 32'(req_ready), 32'd1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // full-word write and read back (R2, R4)
      issue(1'b1, 19'h00000, 16'hA55A, 2'b11);
      issue(1'b0, 19'h00000, 16'h0000, 2'b11);
      // lane isolation (R5)
      issue(1'b1, 19'h12345, 16'h1234, 2'b11);
      issue(1'b1, 19'h12345, 16'hFFCD, 2'b01);
      issue(1'b0, 19'h12345, 16'h0000, 2'b11);
      issue(1'b0, 19'h12345, 16'h0000, 2'b10);
      issue(1'b0, 19'h12345, 16'h0000, 2'b01);
      // high-lane write at the top address (R5, R10)
      issue(1'b1, 19'h7FFFF, 16'hBEEF, 2'b10);
      issue(1'b0, 19'h7FFFF, 16'h0000, 2'b11);
      // empty masks do nothing (R6)
      issue(1'b1, 19'h00000, 16'h0000, 2'b00);
      issue(1'b0, 19'h00000, 16'h0000, 2'b00);
      issue(1'b0, 19'h00000, 16'h0000, 2'b11);
      // read then write back to back (R8), write then read
      issue(1'b0, 19'h7FFFF, 16'h0000, 2'b10);
      issue(1'b1, 19'h000A5, 16'h5AA5, 2'b11);
      issue(1'b0, 19'h000A5, 16'h0000, 2'b11);
      // sweep with rotating masks (R5, R7)
      for (int k = 0; k < 8; k++)
         issue(1'b1, 19'h40010 + 19'(k), 16'(16'h1111 * (k + 1)), 2'(k % 3 + 1));
      for (int k = 0; k < 8; k++)
         issue(1'b0, 19'h40010 + 19'(k), 16'h0000, 2'(3 - k % 3));

      for (int w = 0; w < 100 && sb_q.size() != 0; w++) @(negedge clk);
      chk(sb_q.size() == 0, "R7", "all requests completed", 32'(sb_q.size()), 32'd0);
      repeat (4) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule